// File: doc/BRIEF.md
# DDR3 Module Descriptor Field Decoder

This block sits behind the serial-presence-detect read engine of a memory controller. It takes the module descriptor's leading bytes as a byte stream and holds the fields that the controller set-up needs: address geometry, rank and width organisation, module size, the supported-CAS mask and the minimum timing parameters. Each pulse of `start` begins a new stream at byte index 0. Bytes are accepted on `byte_valid` until index 29 has been taken. The decoder checks every encoded field against its legal range as it decodes it.

When the stream ends, a restoring divider computes the medium timebase as a quotient. A single shared multiplier then scales each raw timing count by the timebase, one timing per cycle. The 12-bit timings are first built from nibbles that share a byte. `done` rises once every output is valid and stays high until the next `start`. A status code reports whether the descriptor has the wrong memory type or holds an illegal field. An illegal field does not stop the decode.

Top module: `spd_field_decoder`

## Requirements
- R1: If byte 2 is not 0x0B, the decoder reports status 1 (wrong type) when it finishes. All geometry, size, CAS and timing outputs then read zero.
- R2: Byte 4 is checked in two parts. Bits 6:4 (bank code) are legal up to 3, and bits 3:0 (density shift) are legal up to 6. Any value beyond these limits gives status 2.
- R3: Row bits equal byte 5 bits 5:3 plus 12, and that field is legal up to 4. Column bits equal byte 5 bits 2:0 plus 9, and that field is legal up to 3. An illegal value gives status 2.
- R4: Ranks equal byte 7 bits 5:3 plus 1. Device width equals 4 shifted left by byte 7 bits 2:0. Each field is legal up to 3, and an illegal value gives status 2.
- R5: The ECC flag is set when byte 8 bits 4:3 are nonzero, and that field is legal up to 1. Bus width equals 8 shifted left by byte 8 bits 2:0, legal up to 3. An illegal value gives status 2.
- R6: Module size in MB equals 2^(density+5) × bus width × ranks / device width, truncated to 32 bits.
- R7: The timebase equals ({byte10, 8'h00}) / byte11, truncated. A zero byte 11 gives status 2 and a timebase of zero.
- R8: The single-byte timings are each multiplied by the timebase: cycle time (byte 12), CAS time (16), write recovery (17), activate-to-read (18), activate-to-activate (19), precharge (20), write-to-read (26) and read-to-precharge (27).
- R9: Four timings combine two bytes before they are multiplied by the timebase. Active time is {byte21[3:0], byte22}. Row cycle is {byte21[7:4], byte23}. Four-activate window is {byte28[3:0], byte29}. Refresh recovery is {byte25, byte24}.
- R10: The CAS mask is {byte15, byte14}.
- R11: Status codes are 0 = ok, 1 = wrong type and 2 = illegal field. Wrong type takes precedence. An illegal field does not stop the decode. Status holds until the next `start`, and `start` clears it to 0.
- R12: `start` clears `done` and restarts capture at index 0. `done` rises after byte 29 and stays high until the next `start`. Bytes that arrive with no capture in progress change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new descriptor stream |
| byte_valid | input | 1 | byte_data carries the next descriptor byte |
| byte_data | input | 8 | Descriptor byte |
| done | output | 1 | All outputs valid |
| status | output | 2 | 0 ok, 1 wrong type, 2 illegal field |
| row_bits | output | 5 | Row address bits |
| col_bits | output | 5 | Column address bits |
| ranks | output | 4 | Number of ranks |
| dev_width | output | 11 | Device data width |
| bus_width | output | 11 | Primary bus width |
| ecc_en | output | 1 | ECC bus extension present |
| size_mb | output | 32 | Module size in MB |
| cas_mask | output | 16 | Supported CAS latency mask |
| t_ck | output | 32 | Minimum cycle time |
| t_aa | output | 32 | Minimum CAS latency time |
| t_wr | output | 32 | Minimum write recovery |
| t_rcd | output | 32 | Minimum activate-to-read delay |
| t_rrd | output | 32 | Minimum activate-to-activate delay |
| t_rp | output | 32 | Minimum precharge time |
| t_ras | output | 32 | Minimum active time |
| t_rc | output | 32 | Minimum row cycle time |
| t_rfc | output | 32 | Minimum refresh recovery |
| t_wtr | output | 32 | Minimum write-to-read delay |
| t_rtp | output | 32 | Minimum read-to-precharge delay |
| t_faw | output | 32 | Minimum four-activate window |

## Verification
A wrong byte index in the capture counter shows as one or more fields read from a neighbouring byte. It appears when `done` rises, at the latest about thirty cycles after the fault. A fault in the divider's remainder logic corrupts every timing output together, because all of them share the timebase. A fault in the multiplier index corrupts one timing and leaves a neighbouring timing at zero, which the per-timing comparison against the timebase isolates. A lost or wrong status bit shows directly on `status` in the same cycle that `done` rises.

// File: rtl/spd_dec_pkg.sv
package spd_dec_pkg;

   typedef enum logic [1:0] {
      ST_OK        = 2'd0,
      ST_BAD_TYPE  = 2'd1,
      ST_BAD_FIELD = 2'd2
   } spd_status_e;

   localparam int         NUM_TIMINGS    = 12;
   localparam int         STREAM_LAST    = 29;
   localparam logic [7:0] DDR3_TYPE_CODE = 8'h0B;

   // output slot of each scaled timing
   localparam int TI_CK  = 0;
   localparam int TI_AA  = 1;
   localparam int TI_WR  = 2;
   localparam int TI_RCD = 3;
   localparam int TI_RRD = 4;
   localparam int TI_RP  = 5;
   localparam int TI_RAS = 6;
   localparam int TI_RC  = 7;
   localparam int TI_RFC = 8;
   localparam int TI_WTR = 9;
   localparam int TI_RTP = 10;
   localparam int TI_FAW = 11;

endpackage

// File: rtl/spd_byte_capture.sv
module spd_byte_capture #(
   parameter int BYTE_W   = 8,
   parameter int LAST_IDX = 29
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             clear,
   input  logic                             byte_valid,
   input  logic [BYTE_W-1:0]                byte_data,
   output logic [LAST_IDX:0][BYTE_W-1:0]    image,
   output logic                             last_seen
);
   localparam int IDX_W = $clog2(LAST_IDX + 2);

   if (LAST_IDX < 1) begin : g_bad_len
      $error("spd_byte_capture: LAST_IDX must be at least 1");
   end

   logic [IDX_W-1:0] idx_q;
   logic             armed_q;
   logic             take;

   assign take = armed_q && byte_valid && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q     <= '0;
         armed_q   <= 1'b0;
         last_seen <= 1'b0;
      end else begin
         last_seen <= take && (idx_q == IDX_W'(LAST_IDX));
         if (clear) begin
            idx_q   <= '0;
            armed_q <= 1'b1;
         end else if (take) begin
            if (idx_q == IDX_W'(LAST_IDX)) armed_q <= 1'b0;
            else                           idx_q   <= idx_q + 1'b1;
         end
      end
   end

   for (genvar g = 0; g <= LAST_IDX; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               image[g] <= '0;
         else if (take && idx_q == IDX_W'(g))      image[g] <= byte_data;
      end
   end

   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IDX_W'(LAST_IDX)); // R12
   AST_DISARM_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      last_seen |-> !armed_q || $past(clear)); // R12

endmodule

// File: rtl/spd_field_decode.sv
module spd_field_decode
   import spd_dec_pkg::*;
#(
   parameter int SIZE_W = 32,
   parameter int RAW_W  = 16
) (
   input  logic [STREAM_LAST:0][7:0]           image,
   output logic                                type_ok,
   output logic                                field_bad,
   output logic [4:0]                          row_bits,
   output logic [4:0]                          col_bits,
   output logic [3:0]                          ranks,
   output logic [10:0]                         dev_width,
   output logic [10:0]                         bus_width,
   output logic                                ecc_en,
   output logic [SIZE_W-1:0]                   size_mb,
   output logic [15:0]                         cas_mask,
   output logic [15:0]                         tb_num,
   output logic [7:0]                          tb_den,
   output logic [NUM_TIMINGS-1:0][RAW_W-1:0]   raw_t
);
   localparam int WIDE_W = 48;

   if (RAW_W < 16) begin : g_bad_raw
      $error("spd_field_decode: RAW_W must hold a 16-bit count");
   end
   if (SIZE_W > WIDE_W) begin : g_bad_size
      $error("spd_field_decode: SIZE_W too wide");
   end

   logic [7:0] b_typ, b_dens, b_addr, b_org, b_bus;
   logic [WIDE_W-1:0] size_wide;
   logic [5:0] up_sh;
   logic [3:0] dn_sh;

   assign b_typ  = image[2];
   assign b_dens = image[4];
   assign b_addr = image[5];
   assign b_org  = image[7];
   assign b_bus  = image[8];

   assign type_ok = (b_typ == DDR3_TYPE_CODE);

   assign field_bad = (b_dens[6:4] > 3'd3) || (b_dens[3:0] > 4'd6) ||
                      (b_addr[5:3] > 3'd4) || (b_addr[2:0] > 3'd3) ||
                      (b_org[5:3]  > 3'd3) || (b_org[2:0]  > 3'd3) ||
                      (b_bus[4:3]  > 2'd1) || (b_bus[2:0]  > 3'd3) ||
                      (image[11] == 8'h00);

   assign row_bits  = 5'd12 + {2'b00, b_addr[5:3]};
   assign col_bits  = 5'd9  + {2'b00, b_addr[2:0]};
   assign ranks     = 4'd1  + {1'b0, b_org[5:3]};
   assign dev_width = 11'd4 << b_org[2:0];
   assign bus_width = 11'd8 << b_bus[2:0];
   assign ecc_en    = |b_bus[4:3];

   // size = ranks * 2^(dens+5) * 2^(bus+3) / 2^(dev+2)
   assign up_sh     = 6'(b_dens[3:0]) + 6'(b_bus[2:0]) + 6'd8;
   assign dn_sh     = 4'(b_org[2:0]) + 4'd2;
   assign size_wide = (WIDE_W'(ranks) << up_sh) >> dn_sh;
   assign size_mb   = size_wide[SIZE_W-1:0];

   assign cas_mask = {image[15], image[14]};
   assign tb_num   = {image[10], 8'h00};
   assign tb_den   = image[11];

   always_comb begin
      raw_t         = '0;
      raw_t[TI_CK]  = RAW_W'(image[12]);
      raw_t[TI_AA]  = RAW_W'(image[16]);
      raw_t[TI_WR]  = RAW_W'(image[17]);
      raw_t[TI_RCD] = RAW_W'(image[18]);
      raw_t[TI_RRD] = RAW_W'(image[19]);
      raw_t[TI_RP]  = RAW_W'(image[20]);
      raw_t[TI_RAS] = RAW_W'({image[21][3:0], image[22]});
      raw_t[TI_RC]  = RAW_W'({image[21][7:4], image[23]});
      raw_t[TI_RFC] = RAW_W'({image[25], image[24]});
      raw_t[TI_WTR] = RAW_W'(image[26]);
      raw_t[TI_RTP] = RAW_W'(image[27]);
      raw_t[TI_FAW] = RAW_W'({image[28][3:0], image[29]});
   end

   logic unused_bytes;
   assign unused_bytes = ^{image[0], image[1], image[3], image[6], image[9],
                           image[13], image[28][7:4], b_dens[7], b_addr[7:6],
                           b_org[7:6], b_bus[7:5], size_wide[WIDE_W-1:SIZE_W]};

endmodule

// File: rtl/spd_mtb_div.sv
module spd_mtb_div #(
   parameter int NUM_W = 16,
   parameter int DEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             done,
   output logic [NUM_W-1:0] quot,
   output logic [DEN_W-1:0] rem
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   if (DEN_W > NUM_W) begin : g_bad_w
      $error("spd_mtb_div: divisor wider than dividend");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic [NUM_W-1:0] num_q;
   logic [DEN_W-1:0] den_q;
   logic [DEN_W:0]   trial;

   assign trial = {rem, quot[NUM_W-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done   <= 1'b0;
         quot   <= '0;
         rem    <= '0;
         num_q  <= '0;
         den_q  <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            quot   <= num;
            num_q  <= num;
            den_q  <= den;
            rem    <= '0;
            cnt_q  <= CNT_W'(NUM_W);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            if (trial >= {1'b0, den_q}) begin
               rem  <= DEN_W'(trial - {1'b0, den_q});
               quot <= {quot[NUM_W-2:0], 1'b1};
            end else begin
               rem  <= trial[DEN_W-1:0];
               quot <= {quot[NUM_W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      done && den_q != '0 |->
         (NUM_W+DEN_W)'(quot) * (NUM_W+DEN_W)'(den_q) + (NUM_W+DEN_W)'(rem)
            == (NUM_W+DEN_W)'(num_q) && rem < den_q); // R7
   AST_DIV_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

endmodule

// File: rtl/spd_timing_scale.sv
module spd_timing_scale #(
   parameter int NT     = 12,
   parameter int RAW_W  = 16,
   parameter int MTB_W  = 16,
   parameter int OUT_W  = 32,
   parameter bit SERIAL = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clear,
   input  logic                        start,
   input  logic [MTB_W-1:0]            mtb,
   input  logic [NT-1:0][RAW_W-1:0]    raw,
   output logic [NT-1:0][OUT_W-1:0]    results,
   output logic                        done
);
   localparam int IDX_W = $clog2(NT);

   if (NT < 2) begin : g_bad_nt
      $error("spd_timing_scale: NT must be at least 2");
   end
   if (OUT_W < RAW_W + MTB_W) begin : g_bad_out
      $error("spd_timing_scale: OUT_W cannot hold the product");
   end

   logic [NT-1:0][OUT_W-1:0] res_q;
   assign results = res_q;

   if (SERIAL) begin : g_serial
      logic [IDX_W-1:0] idx_q;
      logic             run_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            idx_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
            res_q <= '0;
         end else begin
            done <= 1'b0;
            if (clear) begin
               idx_q <= '0;
               run_q <= 1'b0;
               res_q <= '0;
            end else if (start) begin
               idx_q <= '0;
               run_q <= 1'b1;
            end else if (run_q) begin
               res_q[idx_q] <= OUT_W'(raw[idx_q]) * OUT_W'(mtb);
               if (idx_q == IDX_W'(NT - 1)) begin
                  run_q <= 1'b0;
                  done  <= 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
         end
      end

      AST_SCALE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
         run_q |-> idx_q <= IDX_W'(NT - 1)); // R8
      AST_SCALE_MTB_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
         run_q && $past(run_q) && !$past(start) && !$past(clear) |-> $stable(mtb)); // R8
   end else begin : g_parallel
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            done  <= 1'b0;
            res_q <= '0;
         end else begin
            done <= 1'b0;
            if (clear) begin
               res_q <= '0;
            end else if (start) begin
               for (int i = 0; i < NT; i++)
                  res_q[i] <= OUT_W'(raw[i]) * OUT_W'(mtb);
               done <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/spd_field_decoder.sv
module spd_field_decoder
   import spd_dec_pkg::*;
#(
   parameter int  TIME_W       = 32,
   parameter int  SIZE_W       = 32,
   parameter bit  SERIAL_SCALE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   output logic              done,
   output logic [1:0]        status,
   output logic [4:0]        row_bits,
   output logic [4:0]        col_bits,
   output logic [3:0]        ranks,
   output logic [10:0]       dev_width,
   output logic [10:0]       bus_width,
   output logic              ecc_en,
   output logic [SIZE_W-1:0] size_mb,
   output logic [15:0]       cas_mask,
   output logic [TIME_W-1:0] t_ck,
   output logic [TIME_W-1:0] t_aa,
   output logic [TIME_W-1:0] t_wr,
   output logic [TIME_W-1:0] t_rcd,
   output logic [TIME_W-1:0] t_rrd,
   output logic [TIME_W-1:0] t_rp,
   output logic [TIME_W-1:0] t_ras,
   output logic [TIME_W-1:0] t_rc,
   output logic [TIME_W-1:0] t_rfc,
   output logic [TIME_W-1:0] t_wtr,
   output logic [TIME_W-1:0] t_rtp,
   output logic [TIME_W-1:0] t_faw
);
   localparam int RAW_W = 16;
   localparam int MTB_W = 16;
   localparam int DEN_W = 8;

   if (TIME_W < RAW_W + MTB_W) begin : g_bad_time
      $error("spd_field_decoder: TIME_W too narrow for scaled timings");
   end

   typedef enum logic [2:0] {PH_IDLE, PH_CAP, PH_DIV, PH_MUL, PH_DONE} phase_e;
   phase_e ph_q;

   logic [STREAM_LAST:0][7:0]         image;
   logic                              last_seen;
   logic                              type_ok, field_bad;
   logic [4:0]                        d_row, d_col;
   logic [3:0]                        d_ranks;
   logic [10:0]                       d_devw, d_busw;
   logic                              d_ecc;
   logic [SIZE_W-1:0]                 d_size;
   logic [15:0]                       d_cas;
   logic [MTB_W-1:0]                  tb_num;
   logic [DEN_W-1:0]                  tb_den;
   logic [NUM_TIMINGS-1:0][RAW_W-1:0] raw_t;
   logic [NUM_TIMINGS-1:0][TIME_W-1:0] tim;
   logic                              div_start, div_done;
   logic [MTB_W-1:0]                  div_quot;
   logic [DEN_W-1:0]                  div_unused_rem;
   logic                              scale_start, scale_done;
   logic [MTB_W-1:0]                  mtb;
   logic                              den_zero_q;
   spd_status_e                       status_q;

   spd_byte_capture #(.BYTE_W(8), .LAST_IDX(STREAM_LAST)) i_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (start),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .image      (image),
      .last_seen  (last_seen)
   );

   spd_field_decode #(.SIZE_W(SIZE_W), .RAW_W(RAW_W)) i_decode (
      .image     (image),
      .type_ok   (type_ok),
      .field_bad (field_bad),
      .row_bits  (d_row),
      .col_bits  (d_col),
      .ranks     (d_ranks),
      .dev_width (d_devw),
      .bus_width (d_busw),
      .ecc_en    (d_ecc),
      .size_mb   (d_size),
      .cas_mask  (d_cas),
      .tb_num    (tb_num),
      .tb_den    (tb_den),
      .raw_t     (raw_t)
   );

   assign div_start   = (ph_q == PH_CAP) && last_seen && type_ok && !start;
   assign scale_start = (ph_q == PH_DIV) && div_done && !start;
   assign mtb         = den_zero_q ? '0 : div_quot;

   spd_mtb_div #(.NUM_W(MTB_W), .DEN_W(DEN_W)) i_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_start),
      .num   (tb_num),
      .den   (tb_den),
      .done  (div_done),
      .quot  (div_quot),
      .rem   (div_unused_rem)
   );

   spd_timing_scale #(
      .NT     (NUM_TIMINGS),
      .RAW_W  (RAW_W),
      .MTB_W  (MTB_W),
      .OUT_W  (TIME_W),
      .SERIAL (SERIAL_SCALE)
   ) i_scale (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start),
      .start   (scale_start),
      .mtb     (mtb),
      .raw     (raw_t),
      .results (tim),
      .done    (scale_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= PH_IDLE;
      end else if (start) begin
         ph_q <= PH_CAP;
      end else begin
         case (ph_q)
            PH_CAP:  if (last_seen)  ph_q <= type_ok ? PH_DIV : PH_DONE;
            PH_DIV:  if (div_done)   ph_q <= PH_MUL;
            PH_MUL:  if (scale_done) ph_q <= PH_DONE;
            default: ph_q <= ph_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q   <= ST_OK;
         den_zero_q <= 1'b0;
         row_bits   <= '0;
         col_bits   <= '0;
         ranks      <= '0;
         dev_width  <= '0;
         bus_width  <= '0;
         ecc_en     <= 1'b0;
         size_mb    <= '0;
         cas_mask   <= '0;
      end else if (start) begin
         status_q   <= ST_OK;
         den_zero_q <= 1'b0;
         row_bits   <= '0;
         col_bits   <= '0;
         ranks      <= '0;
         dev_width  <= '0;
         bus_width  <= '0;
         ecc_en     <= 1'b0;
         size_mb    <= '0;
         cas_mask   <= '0;
      end else if (ph_q == PH_CAP && last_seen) begin
         if (!type_ok) begin
            status_q <= ST_BAD_TYPE;
         end else begin
            status_q   <= field_bad ? ST_BAD_FIELD : ST_OK;
            den_zero_q <= (tb_den == '0);
            row_bits   <= d_row;
            col_bits   <= d_col;
            ranks      <= d_ranks;
            dev_width  <= d_devw;
            bus_width  <= d_busw;
            ecc_en     <= d_ecc;
            size_mb    <= d_size;
            cas_mask   <= d_cas;
         end
      end
   end

   assign done   = (ph_q == PH_DONE);
   assign status = status_q;

   assign t_ck  = tim[TI_CK];
   assign t_aa  = tim[TI_AA];
   assign t_wr  = tim[TI_WR];
   assign t_rcd = tim[TI_RCD];
   assign t_rrd = tim[TI_RRD];
   assign t_rp  = tim[TI_RP];
   assign t_ras = tim[TI_RAS];
   assign t_rc  = tim[TI_RC];
   assign t_rfc = tim[TI_RFC];
   assign t_wtr = tim[TI_WTR];
   assign t_rtp = tim[TI_RTP];
   assign t_faw = tim[TI_FAW];

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done); // R12
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done && status == 2'd0); // R11
   AST_BAD_TYPE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      done && status == 2'd1 |-> size_mb == '0 && row_bits == '0 && t_ck == '0
                                 && cas_mask == '0); // R1
   AST_ROW_LEGAL_WHEN_OK: assert property (@(posedge clk) disable iff (!rst_n)
      done && status == 2'd0 |-> row_bits >= 5'd12 && row_bits <= 5'd16
                                 && col_bits <= 5'd12); // R3
   AST_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> $stable(status)); // R11

endmodule

// File: tb/test_spd_field_decoder.sv
module test_spd_field_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = 8'h00;
   logic        done;
   logic [1:0]  status;
   logic [4:0]  row_bits, col_bits;
   logic [3:0]  ranks;
   logic [10:0] dev_width, bus_width;
   logic        ecc_en;
   logic [31:0] size_mb;
   logic [15:0] cas_mask;
   logic [31:0] t_ck, t_aa, t_wr, t_rcd, t_rrd, t_rp, t_ras, t_rc, t_rfc,
                t_wtr, t_rtp, t_faw;

   always #4 clk = ~clk;

   spd_field_decoder i_spd_field_decoder (
      .clk(clk), .rst_n(rst_n), .start(start), .byte_valid(byte_valid),
      .byte_data(byte_data), .done(done), .status(status),
      .row_bits(row_bits), .col_bits(col_bits), .ranks(ranks),
      .dev_width(dev_width), .bus_width(bus_width), .ecc_en(ecc_en),
      .size_mb(size_mb), .cas_mask(cas_mask),
      .t_ck(t_ck), .t_aa(t_aa), .t_wr(t_wr), .t_rcd(t_rcd), .t_rrd(t_rrd),
      .t_rp(t_rp), .t_ras(t_ras), .t_rc(t_rc), .t_rfc(t_rfc),
      .t_wtr(t_wtr), .t_rtp(t_rtp), .t_faw(t_faw)
   );

   int  n_vec = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;
   logic [7:0] img [0:29];

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   // ---------------- reference model ----------------
   function automatic bit e_type_ok();
      return img[2] == 8'h0B;
   endfunction

   function automatic logic [1:0] e_status();
      bit bad;
      if (!e_type_ok()) return 2'd1;
      bad = (img[4][6:4] > 3) || (img[4][3:0] > 6) || (img[5][5:3] > 4) ||
            (img[5][2:0] > 3) || (img[7][5:3] > 3) || (img[7][2:0] > 3) ||
            (img[8][4:3] > 1) || (img[8][2:0] > 3) || (img[11] == 0);
      return bad ? 2'd2 : 2'd0;
   endfunction

   function automatic logic [63:0] e_tb();
      if (img[11] == 0) return 0;
      return (64'(img[10]) * 256) / 64'(img[11]);
   endfunction

   function automatic logic [63:0] e_size();
      logic [63:0] r, bw, dw, v;
      r  = 64'(img[7][5:3]) + 1;
      bw = 64'd8 << img[8][2:0];
      dw = 64'd4 << img[7][2:0];
      v  = ((64'd1 << (img[4][3:0] + 5)) * bw * r) / dw;
      return {32'h0, v[31:0]};
   endfunction

   task automatic check_all(input string st_tag);
      bit ok;
      logic [63:0] tb;
      ok = e_type_ok();
      tb = ok ? e_tb() : 64'd0;
      chk("R12", "done", done, 1);
      chk(st_tag, "status", status, e_status());
      chk("R3", "row_bits", row_bits, ok ? 12 + img[5][5:3] : 0);
      chk("R3", "col_bits", col_bits, ok ? 9 + img[5][2:0] : 0);
      chk("R4", "ranks", ranks, ok ? 1 + img[7][5:3] : 0);
      chk("R4", "dev_width", dev_width, ok ? (64'd4 << img[7][2:0]) : 0);
      chk("R5", "bus_width", bus_width, ok ? (64'd8 << img[8][2:0]) : 0);
      chk("R5", "ecc_en", ecc_en, ok ? (img[8][4:3] != 0) : 0);
      chk("R6", "size_mb", size_mb, ok ? e_size() : 0);
      chk("R10", "cas_mask", cas_mask, ok ? {img[15], img[14]} : 0);
      chk("R7", "t_ck", t_ck, img[12] * tb);
      chk("R8", "t_aa", t_aa, img[16] * tb);
      chk("R8", "t_wr", t_wr, img[17] * tb);
      chk("R8", "t_rcd", t_rcd, img[18] * tb);
      chk("R8", "t_rrd", t_rrd, img[19] * tb);
      chk("R8", "t_rp", t_rp, img[20] * tb);
      chk("R9", "t_ras", t_ras, {img[21][3:0], img[22]} * tb);
      chk("R9", "t_rc", t_rc, {img[21][7:4], img[23]} * tb);
      chk("R9", "t_rfc", t_rfc, {img[25], img[24]} * tb);
      chk("R8", "t_wtr", t_wtr, img[26] * tb);
      chk("R8", "t_rtp", t_rtp, img[27] * tb);
      chk("R9", "t_faw", t_faw, {img[28][3:0], img[29]} * tb);
   endtask

   task automatic fill_legal();
      for (int i = 0; i < 30; i++) img[i] = 8'($urandom);
      img[2]  = 8'h0B;
      img[4]  = {1'($urandom), 3'($urandom % 4), 4'($urandom % 7)};
      img[5]  = {2'($urandom), 3'($urandom % 5), 3'($urandom % 4)};
      img[7]  = {2'($urandom), 3'($urandom % 4), 3'($urandom % 4)};
      img[8]  = {3'($urandom), 2'($urandom % 2), 3'($urandom % 4)};
      img[11] = 8'(($urandom % 255) + 1);
   endtask

   task automatic run_image(input int extra);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R12", "done after start", done, 0);
      chk("R11", "status after start", status, 0);
      for (int i = 0; i < 30; i++) begin
         if ($urandom % 4 == 0) begin
            byte_valid = 1'b0;
            @(negedge clk);
         end
         byte_valid = 1'b1;
         byte_data  = img[i];
         @(negedge clk);
      end
      for (int i = 0; i < extra; i++) begin
         byte_valid = 1'b1;
         byte_data  = 8'($urandom);
         @(negedge clk);
      end
      byte_valid = 1'b0;
      for (int w = 0; w < 200 && !done; w++) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R12", "reset done", done, 0);
      chk("R11", "reset status", status, 0);
      chk("R6", "reset size", size_mb, 0);
      chk("R8", "reset t_ck", t_ck, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // bytes with no capture in progress change nothing
      byte_valid = 1'b1;
      byte_data  = 8'hA5;
      repeat (5) @(negedge clk);
      byte_valid = 1'b0;
      chk("R12", "idle bytes done", done, 0);
      chk("R12", "idle bytes size", size_mb, 0);

      // typical legal module
      fill_legal();
      img[4] = 8'h03; img[5] = 8'h19; img[7] = 8'h09; img[8] = 8'h0B;
      img[10] = 8'h01; img[11] = 8'h08;
      run_image(0);
      check_all("R11");

      // stray bytes after completion ignored
      byte_valid = 1'b1;
      for (int i = 0; i < 8; i++) begin
         byte_data = 8'($urandom);
         @(negedge clk);
      end
      byte_valid = 1'b0;
      @(negedge clk);
      check_all("R12");

      // wrong memory type
      fill_legal();
      img[2] = 8'h0C;
      run_image(3);
      check_all("R1");

      // illegal bank code, decode continues
      fill_legal();
      img[4] = 8'h45;
      run_image(0);
      check_all("R2");

      // illegal density shift
      fill_legal();
      img[4] = 8'h07;
      run_image(0);
      check_all("R2");

      // zero timebase divisor
      fill_legal();
      img[11] = 8'h00;
      run_image(0);
      check_all("R7");

      // largest legal values and largest timebase
      fill_legal();
      img[4] = 8'h36; img[5] = 8'h23; img[7] = 8'h18; img[8] = 8'h0B;
      img[10] = 8'hFF; img[11] = 8'h01;
      img[12] = 8'hFF; img[21] = 8'hFF; img[22] = 8'hFF; img[23] = 8'hFF;
      img[24] = 8'hFF; img[25] = 8'hFF; img[28] = 8'hFF; img[29] = 8'hFF;
      run_image(0);
      check_all("R11");

      // random mix: mostly legal, some fully random
      for (int n = 0; n < 220; n++) begin
         fill_legal();
         if ($urandom % 5 == 0)
            for (int i = 0; i < 30; i++) img[i] = 8'($urandom);
         if ($urandom % 10 == 0) img[2] = 8'($urandom);
         run_image($urandom % 4);
         check_all("R11");
      end

      finish_run();
   end

endmodule